// File: doc/BRIEF.md
# Selectable Audio Sample Delay Line

This block holds back a stream of 8-bit audio samples by a selectable number of sample periods. It runs straight from the master oscillator clock. A free-running slot counter splits that clock into fixed frames of 32 cycles, and each frame carries one sample. The sample rate is therefore the clock frequency divided by 32, and every delay in time scales with the clock. Over the allowed clock range of 200 kHz to 1 MHz, a 455 kHz clock gives delays from 18.00 ms to 144.04 ms.

A 3-bit length code selects a delay of 256, 512, and so on up to 2048 samples. The block keeps a circular buffer of 2048 bytes. Late in each frame, once the serial converter's result is valid, the block reads the oldest byte at the current pointer and writes the new byte into the same location. At the close of the frame, the byte that was read appears on the output together with a one-cycle strobe, and the pointer steps forward modulo the active length.

The length code may come straight from board pins. Until the buffer has gone round once, the output holds mid-scale silence.

Top module: `audio_delay_line`

## Requirements
- R1: `out_valid` is high for exactly one cycle once every `FRAME_LEN` cycles. Its first pulse comes `FRAME_LEN` cycles after the first clock edge at which `rst_n` is sampled high.
- R2: Let frames be counted from 0 after reset, and let L = 2^`STEP_W` × (code + 1) be the active length. The strobe that closes frame k presents the byte captured in frame k − L.
- R3: Until one full turn of L frames has passed since reset, each strobe presents mid-scale, 0x80.
- R4: The byte on `sample_in` is taken only in slot `CAPTURE_SLOT` of a frame, where slot 0 is the first cycle of the frame. Values held on the input in any other slot do not reach the output.
- R5: `delay_sel` passes through two synchronizing flops. The code becomes active at the end of the frame in which the synchronized value is present. If the stepped pointer lies outside the new length, it restarts at 0.
- R6: `sample_out` changes only in the cycle in which `out_valid` is high.
- R7: While `rst_n` is low at a clock edge, `sample_out` becomes 0x80 and `out_valid` becomes 0. The slot counter, the pointer, the fill state and the active code (0) all restart. Buffer contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| delay_sel | input | SEL_W | Length code, may be asynchronous |
| sample_in | input | DATA_W | Converted input sample, valid in slot `CAPTURE_SLOT` |
| sample_out | output | DATA_W | Delayed sample |
| out_valid | output | 1 | One-cycle strobe marking a new `sample_out` |

## Verification
A new sample is taken at the edge that ends slot `CAPTURE_SLOT`. Its delayed partner is read at that same edge and loaded into the output at the edge that ends the frame. The bench therefore samples the output on the falling edge of the first cycle of the next frame, exactly when `out_valid` is seen high, and counts falling edges between strobes to confirm the `FRAME_LEN` spacing. A code change made in slot 0 takes two cycles to pass the synchronizer and is applied at the end of that same frame. The bench's reference model therefore applies the code that is on the pins when it scores a frame to the pointer step that ends that frame. The input byte is replaced with its complement for the rest of each frame and restored only one slot before capture.

// File: rtl/adl_pkg.sv
// Package: default geometry shared by the delay line modules and the checker.
// Assumes nothing beyond the defaults being mutually consistent.
package adl_pkg;
    localparam int ADL_DATA_W    = 8;   // bits per audio sample
    localparam int ADL_SEL_W     = 3;   // width of the length code
    localparam int ADL_STEP_W    = 8;   // log2 of samples per length step
    localparam int ADL_FRAME_LEN = 32;  // clocks per sample period
    localparam int ADL_CAP_SLOT  = 30;  // slot in which the input byte is valid
endpackage

// File: rtl/adl_code_sync.sv
// Module: two-flop synchronizer for the length code.
// Assumes the code changes rarely, so a multi-bit skew for one cycle is harmless.
module adl_code_sync #(
    parameter int W = adl_pkg::ADL_SEL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    // Purpose: move the pin value through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/adl_frame_timer.sv
// Module: slot counter that splits the master clock into fixed sample frames.
// Assumes CAP_SLOT lies before the last slot of the frame.
module adl_frame_timer #(
    parameter int FRAME_LEN = adl_pkg::ADL_FRAME_LEN,
    parameter int CAP_SLOT  = adl_pkg::ADL_CAP_SLOT
) (
    input  logic clk,
    input  logic rst_n,
    output logic capture_o,
    output logic frame_end_o
);
    localparam int SLOT_W = $clog2(FRAME_LEN);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_LEN - 1);
    localparam logic [SLOT_W-1:0] CAP  = SLOT_W'(CAP_SLOT);

    logic [SLOT_W-1:0] slot_q;

    // Purpose: advance the slot index, wrapping at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)              slot_q <= '0;
        else if (slot_q == LAST) slot_q <= '0;
        else                     slot_q <= slot_q + 1'b1;
    end

    // Purpose: decode the two slots that the datapath acts on.
    always_comb begin
        capture_o   = (slot_q == CAP);
        frame_end_o = (slot_q == LAST);
    end
endmodule

// File: rtl/adl_addr_ctrl.sv
// Module: circular address pointer, active length and buffer fill state.
// Assumes step_i pulses once per frame, after the frame's memory access.
module adl_addr_ctrl #(
    parameter int SEL_W  = adl_pkg::ADL_SEL_W,
    parameter int STEP_W = adl_pkg::ADL_STEP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_i,
    input  logic [SEL_W-1:0]        code_i,
    output logic [SEL_W+STEP_W-1:0] ptr_o,
    output logic [SEL_W+STEP_W:0]   len_o,
    output logic                    full_o
);
    localparam int ADDR_W = SEL_W + STEP_W;
    localparam int LEN_W  = ADDR_W + 1;

    // Number of samples selected by a code.
    function automatic logic [LEN_W-1:0] len_of(input logic [SEL_W-1:0] c);
        return (LEN_W'(c) + LEN_W'(1)) << STEP_W;
    endfunction

    logic [SEL_W-1:0] code_q;
    logic [LEN_W-1:0] inc;
    logic [LEN_W-1:0] wrapped;
    logic [LEN_W-1:0] folded;
    logic             turn;

    // Purpose: step the pointer, wrap at the old length, fold into the new one.
    always_comb begin
        inc     = LEN_W'(ptr_o) + LEN_W'(1);
        turn    = (inc >= len_o);
        wrapped = turn ? '0 : inc;
        folded  = (wrapped >= len_of(code_i)) ? '0 : wrapped;
    end

    // Purpose: update pointer, active code and fill flag at each frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o  <= '0;
            code_q <= '0;
            full_o <= 1'b0;
        end else if (step_i) begin
            ptr_o  <= folded[ADDR_W-1:0];
            code_q <= code_i;
            if (turn) full_o <= 1'b1;
        end
    end

    // Purpose: expose the length of the active code.
    always_comb len_o = len_of(code_q);
endmodule

// File: rtl/adl_sample_ram.sv
// Module: single-port sample store with read-before-write on a shared access.
// Assumes one access per frame; contents are not reset.
module adl_sample_ram #(
    parameter int DATA_W = adl_pkg::ADL_DATA_W,
    parameter int ADDR_W = adl_pkg::ADL_SEL_W + adl_pkg::ADL_STEP_W
) (
    input  logic              clk,
    input  logic              acc_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: return the old byte and store the new one in the same edge.
    always_ff @(posedge clk) begin
        if (acc_i) begin
            rdata_o      <= mem[addr_i];
            mem[addr_i]  <= wdata_i;
        end
    end
endmodule

// File: rtl/audio_delay_line.sv
// Module: top of the selectable sample delay line.
// Assumes sample_in is valid in slot CAPTURE_SLOT and delay_sel may be asynchronous.
module audio_delay_line #(
    parameter int DATA_W       = adl_pkg::ADL_DATA_W,
    parameter int SEL_W        = adl_pkg::ADL_SEL_W,
    parameter int STEP_W       = adl_pkg::ADL_STEP_W,
    parameter int FRAME_LEN    = adl_pkg::ADL_FRAME_LEN,
    parameter int CAPTURE_SLOT = adl_pkg::ADL_CAP_SLOT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  delay_sel,
    input  logic [DATA_W-1:0] sample_in,
    output logic [DATA_W-1:0] sample_out,
    output logic              out_valid
);
    localparam int ADDR_W = SEL_W + STEP_W;
    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

    logic [SEL_W-1:0]  code_sync;
    logic              capture;
    logic              frame_end;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W:0]   cur_len;
    logic              buf_full;
    logic [DATA_W-1:0] rd_data;

    adl_code_sync #(.W(SEL_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(delay_sel), .sync_o(code_sync)
    );

    adl_frame_timer #(.FRAME_LEN(FRAME_LEN), .CAP_SLOT(CAPTURE_SLOT)) u_timer (
        .clk(clk), .rst_n(rst_n), .capture_o(capture), .frame_end_o(frame_end)
    );

    adl_addr_ctrl #(.SEL_W(SEL_W), .STEP_W(STEP_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .step_i(frame_end), .code_i(code_sync),
        .ptr_o(wr_ptr), .len_o(cur_len), .full_o(buf_full)
    );

    adl_sample_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .acc_i(capture), .addr_i(wr_ptr),
        .wdata_i(sample_in), .rdata_o(rd_data)
    );

    // Purpose: load the delayed byte (or silence before fill) and raise the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out <= MID;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= frame_end;
            if (frame_end) sample_out <= buf_full ? rd_data : MID;
        end
    end
endmodule

// File: rtl/adl_checker.sv
// Module: protocol checker for audio_delay_line, attached by bind.
// Assumes FRAME_LEN > 1. Value-level delay (R2) and capture slot (R4) are left to the bench.
module adl_checker #(
    parameter int DATA_W    = adl_pkg::ADL_DATA_W,
    parameter int ADDR_W    = adl_pkg::ADL_SEL_W + adl_pkg::ADL_STEP_W,
    parameter int FRAME_LEN = adl_pkg::ADL_FRAME_LEN
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic [DATA_W-1:0] sample_out,
    input logic [ADDR_W-1:0] ptr,
    input logic [ADDR_W:0]   cur_len,
    input logic              filled
);
    localparam int GAP_W = $clog2(FRAME_LEN) + 1;
    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    // Purpose: count cycles since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            gap_q  <= out_valid ? '0 : gap_q + 1'b1;
            if (out_valid) seen_q <= 1'b1;
        end
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R1
    AST_STROBE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen_q) |-> (gap_q == GAP_W'(FRAME_LEN - 1))); // R1
    AST_PREFILL_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(filled)) |-> (sample_out == MID)); // R3
    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, ptr} < cur_len)); // R5
    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(sample_out)); // R6
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (sample_out == MID && !out_valid)); // R7
endmodule

bind audio_delay_line adl_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAME_LEN(FRAME_LEN)
) u_adl_checker (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .sample_out(sample_out),
    .ptr(wr_ptr), .cur_len(cur_len), .filled(buf_full)
);

// File: tb/audio_delay_line_bench.sv
module audio_delay_line_bench;
    localparam int B_DATA  = 8;
    localparam int B_SEL   = 3;
    localparam int B_STEP  = 3;
    localparam int B_FRAME = 32;
    localparam int B_CAP   = 30;
    localparam int B_DEPTH = 1 << (B_SEL + B_STEP);

    typedef struct packed {
        logic [2:0] code;
        logic [7:0] frames;
        logic [7:0] seed;
    } phase_t;

    localparam int NPH = 5;
    localparam phase_t PHASES [NPH] = '{
        '{3'd7, 8'd80, 8'd3},
        '{3'd2, 8'd30, 8'd50},
        '{3'd5, 8'd40, 8'd90},
        '{3'd0, 8'd20, 8'd17},
        '{3'd6, 8'd40, 8'd200}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [B_SEL-1:0]  delay_sel = '0;
    logic [B_DATA-1:0] sample_in = '0;
    logic [B_DATA-1:0] sample_out;
    logic              out_valid;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    audio_delay_line #(
        .DATA_W(B_DATA), .SEL_W(B_SEL), .STEP_W(B_STEP),
        .FRAME_LEN(B_FRAME), .CAPTURE_SLOT(B_CAP)
    ) u_audio_delay_line (
        .clk(clk), .rst_n(rst_n), .delay_sel(delay_sel),
        .sample_in(sample_in), .sample_out(sample_out), .out_valid(out_valid)
    );

    // reference model state
    logic [7:0] m_mem [B_DEPTH];
    int         m_ptr;
    logic [2:0] m_code;
    bit         m_full;
    logic [7:0] cur_sample;
    int         since;
    logic [7:0] held;
    bit         unstable;
    int         gk;

    function automatic int len_of(input logic [2:0] c);
        return (int'(c) + 1) << B_STEP;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        since++;
        if (!out_valid && sample_out != held) unstable = 1'b1;
    endtask

    task automatic wait_strobe();
        int n = 0;
        do begin
            tick();
            n++;
        end while (!out_valid && n < 4 * B_FRAME);
    endtask

    // Score one frame: output, spacing, stability, then advance the model.
    task automatic score_frame(input string tag);
        logic [7:0] exp;
        int nxt;
        wait_strobe();
        check("R1 strobe spacing", since, B_FRAME);
        check("R6 output held between strobes", int'(unstable), 0);
        exp = m_full ? m_mem[m_ptr] : 8'h80;
        check(m_full ? tag : "R3 prefill mid-scale", sample_out, exp);
        held = sample_out;
        unstable = 1'b0;
        since = 0;
        m_mem[m_ptr] = cur_sample;
        nxt = m_ptr + 1;
        if (nxt >= len_of(m_code)) begin
            nxt = 0;
            m_full = 1'b1;
        end
        if (nxt >= len_of(delay_sel)) nxt = 0;
        m_ptr = nxt;
        m_code = delay_sel;
    endtask

    // R4: complement on the input for most of the frame, real byte just before capture.
    task automatic drive_next(input logic [7:0] v);
        sample_in = ~v;
        repeat (B_CAP - 1) tick();
        sample_in = v;
        cur_sample = v;
    endtask

    task automatic model_reset();
        m_ptr = 0;
        m_code = '0;
        m_full = 1'b0;
        since = 0;
        held = 8'h80;
        unstable = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        for (int i = 0; i < B_DEPTH; i++) m_mem[i] = 'x;
        gk = 0;
        delay_sel = PHASES[0].code;
        v = 8'(gk * 7 + int'(PHASES[0].seed));
        sample_in = v;
        cur_sample = v;
        repeat (3) @(negedge clk);
        check("R7 reset output mid", sample_out, 8'h80);
        check("R7 reset strobe low", int'(out_valid), 0);
        rst_n = 1'b1;
        model_reset();

        // table walk: each phase runs a code for a number of frames
        for (int p = 0; p < NPH; p++) begin
            for (int f = 0; f < int'(PHASES[p].frames); f++) begin
                score_frame((p > 0 && f < 3) ? "R5 length change" : "R2 delayed value");
                gk++;
                if (f == int'(PHASES[p].frames) - 1 && p + 1 < NPH)
                    delay_sel = PHASES[p+1].code;
                v = 8'(gk * 7 + int'(PHASES[(f == int'(PHASES[p].frames) - 1 && p + 1 < NPH) ? p + 1 : p].seed));
                drive_next(v);
            end
        end

        // directed: reset in mid-run, state check while held
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7 held reset output mid", sample_out, 8'h80);
            check("R7 held reset strobe low", int'(out_valid), 0);
        end
        delay_sel = 3'd1;
        v = 8'h5A;
        sample_in = v;
        cur_sample = v;
        rst_n = 1'b1;
        model_reset();

        // directed: refill after reset, code 1 (16 frames) must give silence first
        for (int f = 0; f < 24; f++) begin
            score_frame("R2 after reset");
            gk++;
            v = 8'(gk * 11 + 1);
            drive_next(v);
        end

        // directed: code 0 shortest length, pointer fold checked through values
        delay_sel = 3'd0;
        for (int f = 0; f < 20; f++) begin
            score_frame(f < 3 ? "R5 shrink to shortest" : "R2 shortest delay");
            gk++;
            v = 8'(gk * 13 + 9);
            drive_next(v);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule